// File: doc/BRIEF.md
# Polled Character Display Port

This block sits on a 16-bit memory-mapped bus and gives software a way to send characters, one at a time, to a display sink. Software reads a status word to learn whether the display can take another character. When it can, software writes the character to a data word. The port then offers that byte to the sink over a valid/ready stream. It waits for the sink to report that the character has been shown, and only then reports readiness again.

The port holds exactly one character. A data write that arrives while the port is busy is dropped without any trace, so software is expected to poll the ready bit before every write. The status word also holds an interrupt-enable bit. When that bit is set, an interrupt request is raised for as long as the port is ready, so software may wait for the request instead of polling.

Back-pressure on the sink side works as follows. Once `char_valid` rises, it stays high and `char_data` stays frozen until a rising clock edge at which `char_ready` is also high. That edge is the transfer. The sink may hold `char_ready` low for as long as it likes. After the transfer, the port waits for a one-cycle `char_done` pulse before it accepts another character.

Top module: `disp_port`

## Requirements
- R1: After reset, a read of the status word (address 0xFE04) returns 0x8000: the ready bit (bit 15) is 1 and the interrupt-enable bit (bit 14) is 0. After reset, `irq` is 0 and `char_valid` is 0.
- R2: A write to the data word (address 0xFE06) while ready is 1 raises `char_valid` from the next cycle. It places write-data bits [7:0] on `char_data`; write-data bits [15:8] are ignored.
- R3: An accepted data write clears the ready bit, so status bit 15 reads 0 from the next cycle on.
- R4: A data write made while ready is 0 has no effect: no character is offered to the sink, and the data-word readback keeps the earlier character.
- R5: A write to the status word stores write-data bit 14 as interrupt-enable, and status bit 14 reads it back. Writing bit 15 does not change ready. All status bits other than 15 and 14 read as 0.
- R6: `irq` is high exactly when ready is 1 and interrupt-enable is 1.
- R7: While `char_valid` is high and `char_ready` is low, `char_valid` stays high and `char_data` does not change. The transfer happens at the first rising edge where both are high, and `char_valid` is low after it.
- R8: A `char_done` pulse that comes after the transfer sets ready to 1 from the next cycle. A `char_done` pulse that comes while ready is 1, or while the character is still being offered, is ignored.
- R9: A read of the data word returns the last accepted character in bits [7:0], with bits [15:8] equal to 0.
- R10: A data write in the same cycle as the `char_done` pulse that completes a character is discarded, because ready is still 0 in that cycle. Ready reads 1 afterwards.
- R11: A read of any address other than 0xFE04 or 0xFE06 returns 0. A write to any such address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| char_valid | output | 1 | Character offered to sink |
| char_ready | input | 1 | Sink can take the character |
| char_data | output | 8 | Character byte |
| char_done | input | 1 | One-cycle pulse: sink finished showing the character |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one clock are the sink's completion pulse and a new data write from software. They collide when software writes in the very cycle that `char_done` arrives, before it has seen ready return. The bench provokes this by switching the sink model to manual control, asserting `char_done` and a data write in the same cycle, and checking three things: no second character appears on the stream, the data readback still holds the first byte, and status reads ready afterwards. A completion pulse during back-pressure, with the character still unaccepted, is provoked the same way and must leave ready at 0.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } disp_st_e;

endpackage

// File: rtl/disp_regdec.sv
module disp_regdec #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 16,
  parameter int          CHAR_W    = 8,
  parameter int          RDY_BIT   = 15,
  parameter int          IE_BIT    = 14,
  parameter logic [15:0] STAT_ADDR = 16'hFE04,
  parameter logic [15:0] DATA_ADDR = 16'hFE06
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              ready,
  input  logic              ie,
  input  logic [CHAR_W-1:0] last_char,
  output logic              stat_wr,
  output logic              data_wr,
  output logic [DATA_W-1:0] rdata
);

  logic hit_stat;
  logic hit_data;

  assign hit_stat = (bus_addr == STAT_ADDR[ADDR_W-1:0]);
  assign hit_data = (bus_addr == DATA_ADDR[ADDR_W-1:0]);

  assign stat_wr = bus_sel && bus_we && hit_stat;
  assign data_wr = bus_sel && bus_we && hit_data;

  always_comb begin
    rdata = '0;
    if (bus_sel && !bus_we) begin
      if (hit_stat) begin
        rdata[RDY_BIT] = ready;
        rdata[IE_BIT]  = ie;
      end else if (hit_data) begin
        rdata[CHAR_W-1:0] = last_char;
      end
    end
  end

endmodule

// File: rtl/disp_ctrl.sv
module disp_ctrl
  import disp_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wr_char,
  input  logic              char_ready,
  input  logic              char_done,
  output logic              ready,
  output logic              char_valid,
  output logic [CHAR_W-1:0] char_data
);

  disp_st_e st_q, st_d;
  logic     take;

  assign ready      = (st_q == ST_IDLE);
  assign char_valid = (st_q == ST_SEND);
  assign take       = data_wr && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (data_wr)    st_d = ST_SEND;
      ST_SEND: if (char_ready) st_d = ST_WAIT;
      ST_WAIT: if (char_done)  st_d = ST_IDLE;
      default:                 st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      char_data <= '0;
    end else begin
      st_q <= st_d;
      if (take) char_data <= wr_char;
    end
  end

  // R2
  offer_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(char_valid) |-> $past(data_wr));

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ready) |=> !ready);

  // R4
  busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !ready) |=> $stable(char_data));

  // R7
  hold_under_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_ready) |=> (char_valid && $stable(char_data)));

  // R8
  done_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !char_valid && char_done) |=> ready);

  // R8
  early_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !char_ready && char_done) |=> !ready);

endmodule

// File: rtl/disp_port.sv
module disp_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        char_valid,
  input  logic        char_ready,
  output logic [7:0]  char_data,
  input  logic        char_done,
  output logic        irq
);

  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;
  localparam int RDY_BIT = DATA_W - 1;
  localparam int IE_BIT  = DATA_W - 2;

  logic stat_wr;
  logic data_wr;
  logic ready;
  logic ie_q;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;

  disp_regdec #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CHAR_W   (CHAR_W),
    .RDY_BIT  (RDY_BIT),
    .IE_BIT   (IE_BIT),
    .STAT_ADDR(16'hFE04),
    .DATA_ADDR(16'hFE06)
  ) u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .ready    (ready),
    .ie       (ie_q),
    .last_char(char_data),
    .stat_wr  (stat_wr),
    .data_wr  (data_wr),
    .rdata    (bus_rdata)
  );

  disp_ctrl #(
    .CHAR_W(CHAR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (data_wr),
    .wr_char   (bus_wdata[CHAR_W-1:0]),
    .char_ready(char_ready),
    .char_done (char_done),
    .ready     (ready),
    .char_valid(char_valid),
    .char_data (char_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ie_q <= 1'b0;
    else if (stat_wr) ie_q <= bus_wdata[IE_BIT];
  end

  assign irq = ready && ie_q;

  // R5
  ie_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (ie_q == $past(bus_wdata[IE_BIT])));

  // R6
  irq_quiet_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_valid |-> !irq);

endmodule

// File: tb/disp_port_test.sv
module disp_port_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        char_valid;
  logic        char_ready = 1'b1;
  logic [7:0]  char_data;
  logic        char_done;
  logic        irq;

  logic auto_done = 1'b0;
  logic man_done  = 1'b0;
  logic auto_sink = 1'b1;
  int   sink_lat  = 2;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  logic done_flag = 1'b0;

  localparam logic [15:0] A_STAT = 16'hFE04;
  localparam logic [15:0] A_DATA = 16'hFE06;

  assign char_done = auto_done | man_done;

  always #4 clk = ~clk;

  disp_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .char_valid(char_valid), .char_ready(char_ready), .char_data(char_data),
    .char_done(char_done), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 1'b0;
  endtask

  // driver: pushes the expected character when the write should be accepted
  task automatic send_char(input logic [15:0] d, input logic expect_take);
    if (expect_take) exp_q.push_back(d[7:0]);
    bus_write(A_DATA, d);
  endtask

  task automatic wait_ready();
    logic [15:0] s;
    for (int i = 0; i < 50; i++) begin
      bus_read(A_STAT, s);
      if (s[15]) break;
    end
  endtask

  // monitor: a transfer is seen at the negedge before the completing posedge
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && char_valid && char_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R4 actual=unexpected char %h expected=none", char_data);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (char_data !== e) begin
            fails++;
            $display("FAIL R2 actual=%h expected=%h", char_data, e);
          end
        end
      end
    end
  end

  // sink model
  initial begin
    forever begin
      @(negedge clk);
      if (auto_sink && char_valid && char_ready) begin
        @(posedge clk);
        repeat (sink_lat) @(posedge clk);
        #1 auto_done = 1'b1;
        @(posedge clk);
        #1 auto_done = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 100000);
    if (!done_flag) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 irq", {15'd0, irq}, 16'd0);
    check("R1 valid", {15'd0, char_valid}, 16'd0);
    bus_read(A_STAT, r);
    check("R1 status", r, 16'h8000);

    // R2 / R3: accepted write, upper bits ignored
    send_char(16'hAB41, 1'b1);
    @(negedge clk);
    check("R2 char_data", {8'd0, char_data}, 16'h0041);
    bus_read(A_STAT, r);
    check("R3 status busy", r, 16'h0000);
    wait_ready();
    bus_read(A_DATA, r);
    check("R9 readback", r, 16'h0041);

    // R5 / R6: interrupt enable, bit15 write has no effect on ready
    bus_write(A_STAT, 16'hFFFF);
    bus_read(A_STAT, r);
    check("R5 status ie", r, 16'hC000);
    @(negedge clk);
    check("R6 irq ready&ie", {15'd0, irq}, 16'd1);

    // R7 back-pressure, plus early done ignored (R8)
    char_ready = 1'b0;
    send_char(16'h0052, 1'b1);
    @(negedge clk);
    check("R6 irq low while busy", {15'd0, irq}, 16'd0);
    auto_sink = 1'b0;
    @(posedge clk); #1 man_done = 1'b1;
    @(posedge clk); #1 man_done = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 valid held", {char_valid, 7'd0, char_data}, 16'h8052);
    end
    bus_read(A_STAT, r);
    check("R8 early done ignored", r, 16'h4000);
    // R4 write while busy
    send_char(16'h0058, 1'b0);
    bus_read(A_DATA, r);
    check("R4 readback unchanged", r, 16'h0052);

    // R10 collision: release, then done together with a new write
    @(posedge clk); #1 char_ready = 1'b1;
    @(posedge clk); #1;
    check("R7 valid low after transfer", {15'd0, char_valid}, 16'd0);
    man_done = 1'b1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_DATA; bus_wdata = 16'h005A;
    @(posedge clk); #1;
    man_done = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    @(negedge clk);
    check("R10 no new offer", {15'd0, char_valid}, 16'd0);
    bus_read(A_STAT, r);
    check("R10 ready back", r, 16'hC000);
    bus_read(A_DATA, r);
    check("R10 readback", r, 16'h0052);

    // R8 done while idle ignored, then normal operation continues
    @(posedge clk); #1 man_done = 1'b1;
    @(posedge clk); #1 man_done = 1'b0;
    bus_read(A_STAT, r);
    check("R8 idle done", r, 16'hC000);
    auto_sink = 1'b1;

    // R5 clear IE
    bus_write(A_STAT, 16'h0000);
    @(negedge clk);
    check("R6 irq off", {15'd0, irq}, 16'd0);

    // R11 other addresses
    bus_write(16'hFE05, 16'h4063);
    bus_write(16'hFE08, 16'h0063);
    bus_read(A_STAT, r);
    check("R11 status untouched", r, 16'h8000);
    bus_read(16'hFE02, r);
    check("R11 read other", r, 16'h0000);

    // several characters back to back with polling
    for (int c = 0; c < 4; c++) begin
      wait_ready();
      send_char(16'h0030 + 16'(c), 1'b1);
    end
    wait_ready();
    bus_read(A_DATA, r);
    check("R9 last char", r, 16'h0033);
    check("R2 scoreboard drained", 16'(exp_q.size()), 16'd0);

    done_flag = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule